// File: doc/BRIEF.md
# Two-Wire Configuration Receiver

This block is the device-side receiver for the configuration word of a programmable clock generator. The data is loaded over two pins that have other jobs in normal operation. The output clock pin acts as the serial clock. The control pin acts as serial data. Both pins are sampled by the local system clock. Each pin passes through a two-flop synchronizer and then a glitch filter, and only then is any edge detected.

After reset the block counts rising edges on the serial clock. The fourth edge puts it in programming mode. In programming mode each rising edge of the serial clock captures one data bit, most significant bit first, until 44 bits are held.

A stop condition ends the session. A stop condition is a falling edge on data while the serial clock stays high. If the word is complete, the stop condition copies the word into the shadow registers, all in one cycle. The shadow registers are:
- tuning capacitor
- fractional multiplier
- prescaler
- test mode
- PLL-use flag
- power-down select
- enable type
- output divider

The block then returns to waiting for the next entry sequence.

Top module: `cfgrx_top`

## Requirements
- R1: After reset, every shadow register reads zero, `progActive` is 0 and `commitDone` is 0.
- R2: Programming mode begins on the fourth filtered rising edge of `pinClk` after reset. After only three rising edges, `progActive` remains 0.
- R3: In programming mode, each rising edge of `pinClk` shifts in the level on `pinData`. The first bit received becomes bit 43 of the word. The word maps to the outputs as follows: bits 43:35 `tuneCap`, 34:16 `fracMul`, 15:13 `preScale`, 12:10 `testMode`, 9 `pllUse`, 8 `pdSelect`, 7 `asyncEn`, 6:0 `outDiv`.
- R4: In programming mode, a falling edge on `pinData` while `pinClk` stays high is a stop condition. If all 44 bits are held, the stop condition loads every shadow register at once, raises `commitDone` for exactly one cycle in that same cycle, and clears `progActive`.
- R5: A stop condition that arrives with fewer than 44 bits held ends the session but leaves every shadow register unchanged, and `commitDone` stays low.
- R6: Rising edges on `pinClk` after the 44th bit, including the one inside the stop sequence, do not change the word.
- R7: Outside programming mode, a falling edge on `pinData` while `pinClk` is high has no effect. `progActive` stays 0 and the shadow registers keep their values.
- R8: A pulse on either pin that is shorter than `FILT_CYC` system clocks is filtered out. It neither captures a bit nor forms a stop condition.
- R9: The shadow registers change only in a cycle in which `commitDone` is high.
- R10: After any stop condition, a new session again needs four rising edges on `pinClk` before bits are captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample both pins |
| rstN | input | 1 | Asynchronous active-low reset |
| pinClk | input | 1 | Raw level of the pin used as serial clock |
| pinData | input | 1 | Raw level of the pin used as serial data |
| tuneCap | output | 9 | Shadow tuning capacitor code |
| fracMul | output | 19 | Shadow fractional multiplier code |
| preScale | output | 3 | Shadow prescaler value |
| testMode | output | 3 | Shadow test mode field |
| pllUse | output | 1 | Shadow flag, 1 = PLL path used |
| pdSelect | output | 1 | Shadow flag, 1 = control pin acts as power down |
| asyncEn | output | 1 | Shadow flag, 1 = asynchronous output enable |
| outDiv | output | 7 | Shadow output divider |
| progActive | output | 1 | High while in programming mode |
| commitDone | output | 1 | One-cycle strobe when the shadow registers load |

## Verification
A level change on a pin reaches the edge detector after 2 synchronizer cycles plus `FILT_CYC` filter cycles. `progActive`, the shadow registers and `commitDone` then update one register stage later, which is 6 system clocks with the default parameters. The bench holds every pin level for 12 clocks and samples only after the final hold of a sequence, on a falling clock edge, so each result has already settled when it is read. `commitDone` lasts only one cycle, so the bench counts its pulses in a monitor and checks that count as a difference across each session.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int TUNE_W = 9;
  localparam int MUL_W  = 19;
  localparam int PRE_W  = 3;
  localparam int TEST_W = 3;
  localparam int DIV_W  = 7;
  localparam int FLAG_N = 3;
  localparam int WORD_LEN = TUNE_W + MUL_W + PRE_W + TEST_W + FLAG_N + DIV_W;
  localparam int CNT_W = $clog2(WORD_LEN + 1);

  // Field order follows arrival order: first field received sits at the MSB.
  typedef struct packed {
    logic [TUNE_W-1:0] tune;
    logic [MUL_W-1:0]  mul;
    logic [PRE_W-1:0]  pre;
    logic [TEST_W-1:0] test;
    logic              pllUse;
    logic              pdSel;
    logic              asyncEn;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  typedef struct packed {
    logic shiftBit;
    logic clearWord;
    logic commitWord;
  } strobe_t;

  typedef enum logic {ST_WAIT, ST_PROG} state_t;
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
  parameter int N_PINS   = 2,
  parameter int FILT_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PINS-1:0] rawIn,
  output logic [N_PINS-1:0] filtOut
);
  localparam int FC_W = $clog2(FILT_CYC + 1);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FILT_CYC - 1);

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic meta, sync;
    logic [FC_W-1:0] runCnt;
    logic level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b0;
        sync <= 1'b0;
      end else begin
        meta <= rawIn[g];
        sync <= meta;
      end
    end

    // The filtered level follows only after FILT_CYC consecutive disagreeing samples
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
        level  <= 1'b0;
      end else if (sync == level) begin
        runCnt <= '0;
      end else if (runCnt == FC_LAST) begin
        runCnt <= '0;
        level  <= sync;
      end else begin
        runCnt <= runCnt + FC_W'(1);
      end
    end

    assign filtOut[g] = level;
  end
endmodule

// File: rtl/cfgrx_ctrl.sv
module cfgrx_ctrl
  import cfgrx_pkg::*;
#(
  parameter int ENTRY_PULSES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkF,
  input  logic    sdatF,
  input  logic    wordFull,
  output strobe_t strobe,
  output logic    progActive
);
  localparam int PC_W = $clog2(ENTRY_PULSES + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(ENTRY_PULSES - 1);

  state_t state;
  logic [PC_W-1:0] pulseCnt;
  logic sclkPrev, sdatPrev;
  logic sclkRise, stopCond;

  assign sclkRise = sclkF & ~sclkPrev;
  // data falls while the clock was high and is still high
  assign stopCond = sclkF & sclkPrev & sdatPrev & ~sdatF;

  always_comb begin
    strobe = '0;
    if (state == ST_PROG) begin
      strobe.shiftBit   = sclkRise & ~wordFull;
      strobe.clearWord  = stopCond;
      strobe.commitWord = stopCond & wordFull;
    end else begin
      strobe.clearWord  = sclkRise && (pulseCnt == PC_LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      sdatPrev <= 1'b0;
      state    <= ST_WAIT;
      pulseCnt <= '0;
    end else begin
      sclkPrev <= sclkF;
      sdatPrev <= sdatF;
      case (state)
        ST_WAIT: begin
          if (sclkRise) begin
            if (pulseCnt == PC_LAST) begin
              state    <= ST_PROG;
              pulseCnt <= '0;
            end else begin
              pulseCnt <= pulseCnt + PC_W'(1);
            end
          end
        end
        default: begin
          if (stopCond) begin
            state    <= ST_WAIT;
            pulseCnt <= '0;
          end
        end
      endcase
    end
  end

  assign progActive = (state == ST_PROG);
endmodule

// File: rtl/cfgrx_dpath.sv
module cfgrx_dpath
  import cfgrx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sdatF,
  input  strobe_t strobe,
  output logic    wordFull,
  output cfg_t    cfgReg,
  output logic    commitDone
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_LEN);

  logic [WORD_LEN-1:0] shiftReg;
  logic [CNT_W-1:0]    bitCnt;

  assign wordFull = (bitCnt == CNT_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobe.clearWord) begin
      bitCnt <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[WORD_LEN-2:0], sdatF};
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg     <= '0;
      commitDone <= 1'b0;
    end else begin
      commitDone <= strobe.commitWord;
      if (strobe.commitWord) cfgReg <= cfg_t'(shiftReg);
    end
  end
endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top
  import cfgrx_pkg::*;
#(
  parameter int FILT_CYC     = 3,
  parameter int ENTRY_PULSES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinClk,
  input  logic              pinData,
  output logic [TUNE_W-1:0] tuneCap,
  output logic [MUL_W-1:0]  fracMul,
  output logic [PRE_W-1:0]  preScale,
  output logic [TEST_W-1:0] testMode,
  output logic              pllUse,
  output logic              pdSelect,
  output logic              asyncEn,
  output logic [DIV_W-1:0]  outDiv,
  output logic              progActive,
  output logic              commitDone
);
  logic [1:0] pinsF;
  strobe_t    strobe;
  logic       wordFull;
  cfg_t       cfgReg;

  cfgrx_sync #(.N_PINS(2), .FILT_CYC(FILT_CYC)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({pinData, pinClk}), .filtOut(pinsF)
  );

  cfgrx_ctrl #(.ENTRY_PULSES(ENTRY_PULSES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkF(pinsF[0]), .sdatF(pinsF[1]),
    .wordFull(wordFull), .strobe(strobe), .progActive(progActive)
  );

  cfgrx_dpath u_dp (
    .clk(clk), .rstN(rstN), .sdatF(pinsF[1]), .strobe(strobe),
    .wordFull(wordFull), .cfgReg(cfgReg), .commitDone(commitDone)
  );

  assign tuneCap  = cfgReg.tune;
  assign fracMul  = cfgReg.mul;
  assign preScale = cfgReg.pre;
  assign testMode = cfgReg.test;
  assign pllUse   = cfgReg.pllUse;
  assign pdSelect = cfgReg.pdSel;
  assign asyncEn  = cfgReg.asyncEn;
  assign outDiv   = cfgReg.div;
endmodule

// File: rtl/cfgrx_chk.sv
module cfgrx_chk
  import cfgrx_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                progActive,
  input logic                commitDone,
  input logic [WORD_LEN-1:0] cfgAll,
  input logic [CNT_W-1:0]    bitCnt
);
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitDone |-> $stable(cfgAll));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);
  // R4
  done_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> ($past(progActive) && !progActive));
  // R5
  done_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> ($past(bitCnt) == CNT_W'(WORD_LEN)));
  // R6
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_LEN));
endmodule

bind cfgrx_top cfgrx_chk u_chk (
  .clk(clk), .rstN(rstN), .progActive(progActive), .commitDone(commitDone),
  .cfgAll({tuneCap, fracMul, preScale, testMode, pllUse, pdSelect, asyncEn, outDiv}),
  .bitCnt(u_dp.bitCnt)
);

// File: tb/sim_cfgrx_top.sv
module sim_cfgrx_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;
  localparam int WLEN = 44;
  localparam int N_VEC = 4;
  localparam int WD_LIMIT = 150000;

  localparam logic [8:0]  V_T [N_VEC] = '{9'h1A5, 9'h1FF, 9'h000, 9'h0AA};
  localparam logic [18:0] V_M [N_VEC] = '{19'h32000, 19'h7FFFF, 19'h15400, 19'h55555};
  localparam logic [2:0]  V_P [N_VEC] = '{3'd2, 3'd7, 3'd1, 3'd5};
  localparam logic [2:0]  V_F [N_VEC] = '{3'd0, 3'd7, 3'd0, 3'd2};
  localparam logic [2:0]  V_B [N_VEC] = '{3'b101, 3'b111, 3'b010, 3'b001};
  localparam logic [6:0]  V_D [N_VEC] = '{7'd6, 7'h7F, 7'd1, 7'h2A};

  logic clk = 1'b0, rstN = 1'b0, pinClk = 1'b0, pinData = 1'b0;
  logic [8:0] tuneCap; logic [18:0] fracMul; logic [2:0] preScale, testMode;
  logic pllUse, pdSelect, asyncEn, progActive, commitDone; logic [6:0] outDiv;
  int checkCnt = 0, passCnt = 0, doneCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgrx_top u0 (.clk(clk), .rstN(rstN), .pinClk(pinClk), .pinData(pinData),
    .tuneCap(tuneCap), .fracMul(fracMul), .preScale(preScale), .testMode(testMode),
    .pllUse(pllUse), .pdSelect(pdSelect), .asyncEn(asyncEn), .outDiv(outDiv),
    .progActive(progActive), .commitDone(commitDone));

  always @(posedge clk) if (rstN && commitDone) doneCnt++;

  function automatic logic [WLEN-1:0] vecWord(int i);
    return {V_T[i], V_M[i], V_P[i], V_F[i], V_B[i], V_D[i]};
  endfunction

  function automatic logic [WLEN-1:0] outWord();
    return {tuneCap, fracMul, preScale, testMode, pllUse, pdSelect, asyncEn, outDiv};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic settle(int n); repeat (n) @(negedge clk); endtask
  task automatic drive(logic c, logic d); pinClk = c; pinData = d; settle(HOLD); endtask

  task automatic pulses(int n);
    for (int k = 0; k < n; k++) begin drive(1'b1, 1'b0); drive(1'b0, 1'b0); end
  endtask

  task automatic sendBit(logic b);
    drive(1'b0, b); drive(1'b1, b); drive(1'b0, b);
  endtask

  task automatic sendWord(logic [WLEN-1:0] w, int nBits);
    for (int k = WLEN - 1; k >= WLEN - nBits; k--) sendBit(w[k]);
  endtask

  task automatic stopSeq();
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b0, 1'b0);
  endtask

  task automatic doReset();
    pinClk = 1'b0; pinData = 1'b0; rstN = 1'b0; settle(4); rstN = 1'b1; settle(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checkCnt++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_LIMIT, WD_LIMIT);
    summary();
  end

  initial begin
    int d0;
    logic [WLEN-1:0] w;
    doReset();
    // R1 reset state
    check(outWord() == '0 && !progActive && !commitDone, "R1",
          {outWord(), progActive}, 64'h0);

    // table walk: R3 field layout, R4 commit and single done pulse
    for (int i = 0; i < N_VEC; i++) begin
      d0 = doneCnt;
      pulses(4);
      sendWord(vecWord(i), WLEN);
      stopSeq();
      check(outWord() == vecWord(i), "R3", outWord(), vecWord(i));
      check(doneCnt == d0 + 1 && !progActive, "R4", doneCnt - d0, 1);
    end

    // R2: three pulses do not enter, the fourth does
    pulses(3);
    check(!progActive, "R2", progActive, 0);
    pulses(1);
    check(progActive, "R2", progActive, 1);

    // R5: short word then stop
    d0 = doneCnt;
    sendWord(vecWord(0), 20);
    stopSeq();
    check(outWord() == vecWord(3) && doneCnt == d0 && !progActive, "R5",
          outWord(), vecWord(3));

    // R10: fresh session needs four pulses again
    pulses(3);
    check(!progActive, "R10", progActive, 0);
    pulses(1);
    check(progActive, "R10", progActive, 1);

    // R6: three extra bits after the full word are ignored
    sendWord(vecWord(0), WLEN);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    stopSeq();
    check(outWord() == vecWord(0), "R6", outWord(), vecWord(0));

    // R8: short pulses on clock and data are filtered
    pulses(4);
    w = vecWord(1);
    pinClk = 1'b1; settle(1); pinClk = 1'b0; settle(HOLD);
    drive(1'b0, w[WLEN-1]);
    drive(1'b1, w[WLEN-1]);
    pinData = 1'b0; settle(1); pinData = 1'b1; settle(HOLD);
    check(progActive, "R8", progActive, 1);
    drive(1'b0, w[WLEN-1]);
    sendWord(w, WLEN - 1 + 1 - 1 + 0 == 0 ? 0 : WLEN - 1 + 0);
    stopSeq();
    check(outWord() == vecWord(1), "R8", outWord(), vecWord(1));

    // R7: stop-shaped sequence outside programming mode
    doReset();
    d0 = doneCnt;
    stopSeq();
    check(!progActive && outWord() == '0 && doneCnt == d0, "R7",
          {outWord(), progActive}, 64'h0);

    // R9: registers hold when no session is committed
    settle(HOLD);
    check(outWord() == '0, "R9", outWord(), 64'h0);

    summary();
  end
endmodule